// File: doc/BRIEF.md
# Stepped Horizontal/Vertical Position Timer

This block tracks a beam-like position made of a horizontal count and a line count. Time is not fed one cycle at a time. On each update strobe the caller supplies how many cycles have gone by since the last update, and the horizontal count jumps forward by that amount. When the horizontal count reaches its range limit, the limit is subtracted from it and the line count steps on by one. The line count returns to zero at its own limit. In linear mode both limits are fixed at 2048 and 512. In video mode both come from inputs, which gives a line length and a line total that follow the display timing.

A timer event can be armed on a horizontal position, on a line number, or on both together. The horizontal count moves in jumps and may skip over the target value. A horizontal hit is therefore counted when the target lies between the count before the update (excluded) and the count after it (included). The horizontal target is the programmed dot position times a fixed number of cycles per dot. The block keeps the last result of the combined match and emits a one-cycle pulse only when that result changes from false to true. The pulse goes to an interrupt arbiter.

Top module: `hv_step_timer`

## Requirements
- R1: While reset is asserted and after it is released, `h_count` and `v_count` read 0 and `evt` is low. The stored match state starts false.
- R2: On a clock edge with `upd` high, `h_count` becomes the old count plus `delta` (before any wrap). The new value is visible from the next cycle. With `upd` low, `h_count`, `v_count` and the match state keep their values.
- R3: With `mode_lin` high, a horizontal sum of 2048 or more wraps by subtracting 2048 and increments `v_count`. `v_count` goes back to 0 when it would reach 512.
- R4: With `mode_lin` low, the horizontal limit is `line_len` and the line limit is `line_cnt`, under the same subtract-and-increment rule.
- R5: With `h_en` and `v_en` both low, `evt` never pulses.
- R6: With `h_en` high, the horizontal part of the match is true when prev < T <= new. Here T = `h_target`*4, new is the updated count, and prev is the count before the update, reduced by the horizontal limit when the update wraps. A wrap can therefore cross T = 0.
- R7: With `v_en` high, the match also requires the updated `v_count` to equal `v_target`.
- R8: With both enables high, the match requires the horizontal crossing and the line equality in the same update.
- R9: `evt` is high for exactly one cycle, in the cycle after an update whose match is true while the stored match state was false. The match state is stored on every update, so a match that stays true does not pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd | input | 1 | Update strobe |
| delta | input | 12 | Cycles elapsed since the previous update |
| mode_lin | input | 1 | 1: fixed 2048 x 512 range, 0: video range |
| h_en | input | 1 | Arm the horizontal crossing match |
| v_en | input | 1 | Arm the line equality match |
| h_target | input | 9 | Horizontal target in dots |
| v_target | input | 9 | Target line |
| line_len | input | 12 | Horizontal limit in video mode |
| line_cnt | input | 9 | Line limit in video mode |
| h_count | output | 12 | Current horizontal count |
| v_count | output | 9 | Current line count |
| evt | output | 1 | One-cycle timer event |

## Verification
The hardest case to reach is a horizontal hit produced only by a wrap. The count must pass through the limit so that the adjusted previous value becomes negative while the target is at dot 0. The stimulus steps the count by 100 cycles until the 21st update lands just past 2048. A second hard case is a line-only match that stays true across two updates. Using 1024-cycle steps, each line is visited twice, which shows that the stored match state suppresses a second pulse. Wrapping the line count back to zero takes over a thousand updates, and a long run of fixed steps makes the count pass 512 lines.

// File: rtl/hv_step_timer.sv
module hv_step_timer #(
  parameter int HW    = 12,
  parameter int VW    = 9,
  parameter int DW    = 12,
  parameter int PW    = 9,
  parameter int DOT   = 4,
  parameter int LIN_H = 2048,
  parameter int LIN_V = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] delta,
  input  logic          mode_lin,
  input  logic          h_en,
  input  logic          v_en,
  input  logic [PW-1:0] h_target,
  input  logic [VW-1:0] v_target,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] line_cnt,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic          evt
);
  localparam int AW = HW + 2;
  localparam int VX = VW + 1;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          last_q;
  logic          evt_q;

  logic [AW-1:0]        h_sum, h_lim, h_nxt;
  logic signed [AW-1:0] prev_adj, tgt;
  logic [VX-1:0]        v_lim, v_inc;
  logic [VW-1:0]        v_nxt;
  logic                 wrap, h_hit, v_hit, cond;

  assign h_sum = AW'(h_q) + AW'(delta);
  assign h_lim = mode_lin ? AW'(LIN_H) : AW'(line_len);
  assign wrap  = h_sum >= h_lim;
  assign h_nxt = wrap ? h_sum - h_lim : h_sum;
  assign prev_adj = wrap ? $signed(AW'(h_q)) - $signed(h_lim) : $signed(AW'(h_q));
  assign tgt   = $signed(AW'(h_target) * AW'(DOT));

  assign v_lim = mode_lin ? VX'(LIN_V) : VX'(line_cnt);
  assign v_inc = VX'(v_q) + VX'(1);
  assign v_nxt = !wrap ? v_q : (v_inc >= v_lim) ? '0 : v_inc[VW-1:0];

  assign h_hit = (prev_adj < tgt) && ($signed(h_nxt) >= tgt);
  assign v_hit = v_nxt == v_target;
  assign cond  = (h_en || v_en) && (!h_en || h_hit) && (!v_en || v_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      v_q    <= '0;
      last_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (upd) begin
        h_q    <= h_nxt[HW-1:0];
        v_q    <= v_nxt;
        last_q <= cond;
        evt_q  <= cond && !last_q;
      end
    end
  end

  assign h_count = h_q;
  assign v_count = v_q;
  assign evt     = evt_q;
endmodule

// File: rtl/hv_step_timer_chk.sv
module hv_step_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd,
  input logic [11:0] delta,
  input logic        mode_lin,
  input logic        h_en,
  input logic        v_en,
  input logic [11:0] h_count,
  input logic [8:0]  v_count,
  input logic        evt
);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(h_count) && $stable(v_count)));
  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R9
  evt_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(upd));
  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !h_en && !v_en) |=> !evt);
  // R3
  lin_vwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode_lin && v_count == 9'd511 && ({1'b0, h_count} + {1'b0, delta}) >= 13'd2048)
      |=> v_count == 9'd0);
  // R3
  lin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode_lin && h_count < 12'd2048 && delta < 12'd2048) |=> h_count < 12'd2048);
endmodule

bind hv_step_timer hv_step_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .delta(delta), .mode_lin(mode_lin),
  .h_en(h_en), .v_en(v_en), .h_count(h_count), .v_count(v_count), .evt(evt)
);

// File: tb/sim_hv_step_timer.sv
module sim_hv_step_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [11:0] delta = '0;
  logic        mode_lin = 1'b1, h_en = 1'b0, v_en = 1'b0;
  logic [8:0]  h_target = '0, v_target = '0;
  logic [11:0] line_len = 12'd300;
  logic [8:0]  line_cnt = 9'd3;
  logic [11:0] h_count;
  logic [8:0]  v_count;
  logic        evt;

  int total = 0, bad = 0, ecount = 0;
  int mh = 0, mv = 0, mlast = 0, mevt = 0;

  always #10 clk = ~clk;

  hv_step_timer u0 (
    .clk(clk), .rst_n(rst_n), .upd(upd), .delta(delta), .mode_lin(mode_lin),
    .h_en(h_en), .v_en(v_en), .h_target(h_target), .v_target(v_target),
    .line_len(line_len), .line_cnt(line_cnt),
    .h_count(h_count), .v_count(v_count), .evt(evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mlast = 0; mevt = 0;
    end else begin
      mevt = 0;
      if (upd) begin
        int hl, vl, prev, t, c;
        hl = mode_lin ? 2048 : int'(line_len);
        vl = mode_lin ? 512 : int'(line_cnt);
        prev = mh;
        mh = mh + int'(delta);
        if (mh >= hl) begin
          mh -= hl; prev -= hl; mv++;
          if (mv >= vl) mv = 0;
        end
        t = int'(h_target) * 4;
        c = (h_en || v_en) ? 1 : 0;
        if (h_en && !(prev < t && mh >= t)) c = 0;
        if (v_en && mv != int'(v_target)) c = 0;
        mevt = (c == 1 && mlast == 0) ? 1 : 0;
        mlast = c;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(h_count) == mh, "R2 h_count", int'(h_count), mh);
      chk(int'(v_count) == mv, "R3/R4 v_count", int'(v_count), mv);
      chk(int'(evt) == mevt, "R9 evt", int'(evt), mevt);
      if (evt) ecount++;
    end
  end

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    upd = 1'b0;
    repeat (2) @(negedge clk);
    chk(h_count == 0 && v_count == 0 && !evt, "R1 reset", int'(h_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ecount = 0;
  endtask

  task automatic steps(input int d, input int n);
    for (int i = 0; i < n; i++) begin
      upd = 1'b1;
      delta = 12'(d);
      @(negedge clk);
    end
    upd = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 / R2
    restart();
    chk(h_count == 0 && v_count == 0, "R1 after release", int'(h_count), 0);
    mode_lin = 1; h_en = 0; v_en = 0;
    steps(100, 5);
    chk(h_count == 500, "R2 accumulate", int'(h_count), 500);
    repeat (5) @(negedge clk);
    chk(h_count == 500, "R2 hold idle", int'(h_count), 500);
    chk(ecount == 0, "R5 no enable", ecount, 0);

    // R6 crossing of 200 on two lines
    restart();
    h_en = 1; h_target = 9'd50;
    steps(64, 40);
    chk(ecount == 2, "R6 crossings", ecount, 2);
    chk(v_count == 1, "R3 h wrap to line 1", int'(v_count), 1);

    // R6 crossing created by wrap, target 0
    restart();
    h_target = 9'd0;
    steps(100, 20);
    chk(ecount == 0, "R6 no hit before wrap", ecount, 0);
    steps(100, 1);
    chk(ecount == 1, "R6 wrap crossing", ecount, 1);
    chk(h_count == 52, "R3 wrap remainder", int'(h_count), 52);

    // R7 line match held over two updates pulses once (R9)
    restart();
    h_en = 0; v_en = 1; v_target = 9'd3;
    steps(1024, 20);
    chk(ecount == 1, "R7/R9 single pulse", ecount, 1);

    // R8 both enables
    restart();
    h_en = 1; v_en = 1; h_target = 9'd100; v_target = 9'd1;
    steps(300, 16);
    chk(ecount == 1, "R8 combined", ecount, 1);

    // R5 same stimulus, disabled
    restart();
    h_en = 0; v_en = 0;
    steps(300, 16);
    chk(ecount == 0, "R5 disabled", ecount, 0);

    // R4 video mode
    restart();
    mode_lin = 0; line_len = 12'd300; line_cnt = 9'd3;
    steps(100, 4);
    chk(h_count == 100 && v_count == 1, "R4 line wrap", int'(v_count), 1);
    steps(100, 5);
    chk(h_count == 0 && v_count == 0, "R4 frame wrap", int'(v_count), 0);

    // R3 linear line count wrap at 512
    restart();
    mode_lin = 1;
    steps(1024, 1024);
    chk(v_count == 0 && h_count == 0, "R3 v wrap", int'(v_count), 0);
    steps(1024, 2);
    chk(v_count == 1, "R3 after v wrap", int'(v_count), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule